// File: doc/BRIEF.md
# Parking Address Bus Arbiter

This block decides which master may start the next address tenure on a split-transaction processor bus. One internal master and `N_EXT` external masters share the bus. Each external master has a request input and a grant output. The internal master's grant is a separate output that is meant to stay inside the chip. When nobody asks for the bus, the grant rests on the internal master. That master can then begin a tenure with a tenure-start pulse without requesting first, which saves a cycle of latency.

Grant decisions are made at a few points only. While the bus is idle, the arbiter re-arbitrates every cycle. When the parked master starts a tenure while an external request is pending, the grant passes to that requester. At the address-acknowledge cycle, the requests are sampled to choose the next owner. Between tenure start and acknowledge, the grant is frozen. The cycle after an acknowledge is the retry window. An address retry in that window withdraws every grant for that cycle and the one after it, and the arbiter then chooses again.

The controller is a four-state machine:
- `ST_IDLE`: no tenure is in flight.
- `ST_TENURE`: a tenure is in flight.
- `ST_WINDOW`: the retry window after acknowledge.
- `ST_BLOCK`: the grant hold-off after a retry.

The transitions are:
- IDLE→TENURE on tenure start.
- TENURE→WINDOW on acknowledge.
- WINDOW→BLOCK on retry.
- WINDOW→TENURE on tenure start without retry.
- WINDOW→IDLE otherwise.
- BLOCK→IDLE always.

Top module: `addr_bus_arbiter`

## Requirements
- R1: After reset, `int_gnt` is 1, `ext_gnt` is all zeros and the controller is idle.
- R2: While the bus is idle and no `ext_req` bit is set, the grant parks on the internal master one cycle later.
- R3: While the bus is idle and `tenure_start` is low, a set `ext_req` bit moves the grant to an external master one cycle later.
- R4: Among several external requesters, the lowest index wins: `ext_req[0]` beats `ext_req[1]`, and so on.
- R5: If `tenure_start` is seen while the grant is held by the internal master and some `ext_req` bit is set, the grant moves to the winning external master in the next cycle, and a tenure begins.
- R6: From the cycle after `tenure_start` until `addr_ack`, the grant outputs do not change, whatever `ext_req` does.
- R7: `ext_req` is sampled in the `addr_ack` cycle. The next cycle shows the winner, or `int_gnt` if no bit was set. A master that dropped its request before then loses its grant.
- R8: `addr_retry` in the cycle after `addr_ack` clears all grants in that cycle and the next one. The cycle after that shows the winner sampled during the hold-off. Without a retry, that window cycle behaves like idle and accepts `tenure_start`.
- R9: At most one of `int_gnt` and the `ext_gnt` bits is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tenure_start | input | 1 | Address tenure start pulse from the current grant holder |
| addr_ack | input | 1 | Address acknowledge, ends the tenure |
| addr_retry | input | 1 | Address retry, valid in the cycle after acknowledge |
| ext_req | input | N_EXT | External bus requests, bit 0 has the highest priority |
| int_gnt | output | 1 | Grant to the internal (parked) master |
| ext_gnt | output | N_EXT | Grants to the external masters |

## Verification
A controller stuck in the wrong state shows up within one cycle at the grant pins. Examples:
- A machine left in TENURE ignores requests while the bus is idle.
- A machine that skips WINDOW lets a retry pass with a grant still visible.
- A machine that skips BLOCK shows a grant one cycle too early.

A corrupted grant register shows up immediately, either as two grants at once or as a grant to a master that did not win under lowest-index priority. The directed sequences therefore check the grant pins in the exact cycle after each tenure start, acknowledge and retry.

// File: rtl/abr_pkg.sv
package abr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TENURE = 2'd1,
        ST_WINDOW = 2'd2,
        ST_BLOCK  = 2'd3
    } abr_state_e;
endpackage

// File: rtl/abr_prio_pick.sv
// Lowest-index external requester wins; bit 0 of pick is the park choice.
module abr_prio_pick #(
    parameter int N_EXT = 2
) (
    input  logic [N_EXT-1:0] req,
    output logic [N_EXT:0]   pick
);
    assign pick[0] = ~|req;

    for (genvar i = 0; i < N_EXT; i++) begin : g_pick
        if (i == 0) begin : g_first
            assign pick[1] = req[0];
        end else begin : g_rest
            assign pick[i+1] = req[i] & ~|req[i-1:0];
        end
    end
endmodule

// File: rtl/abr_grant_hold.sv
// Grant register (one-hot, bit 0 = internal) with an output mask.
module abr_grant_hold #(
    parameter int GW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [GW-1:0] din,
    input  logic          mask,
    output logic [GW-1:0] held,
    output logic [GW-1:0] gnt
);
    localparam logic [GW-1:0] PARK = GW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    held <= PARK;
        else if (load) held <= din;
    end

    always_comb begin
        gnt = mask ? '0 : held;
    end
endmodule

// File: rtl/addr_bus_arbiter.sv
module addr_bus_arbiter #(
    parameter int N_EXT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tenure_start,
    input  logic             addr_ack,
    input  logic             addr_retry,
    input  logic [N_EXT-1:0] ext_req,
    output logic             int_gnt,
    output logic [N_EXT-1:0] ext_gnt
);
    import abr_pkg::*;

    localparam int GW = N_EXT + 1;

    abr_state_e    state_q, state_d;
    logic          load, mask;
    logic [GW-1:0] winner, held, gnt_vec;

    abr_prio_pick #(.N_EXT(N_EXT)) pick_i (
        .req  (ext_req),
        .pick (winner)
    );

    abr_grant_hold #(.GW(GW)) hold_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .din   (winner),
        .mask  (mask),
        .held  (held),
        .gnt   (gnt_vec)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state, grant load and mask
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        mask    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tenure_start) begin
                    state_d = ST_TENURE;
                    load    = held[0] & (|ext_req);
                end else begin
                    load    = 1'b1;
                end
            end
            ST_TENURE: begin
                if (addr_ack) begin
                    state_d = ST_WINDOW;
                    load    = 1'b1;
                end
            end
            ST_WINDOW: begin
                if (addr_retry) begin
                    state_d = ST_BLOCK;
                    mask    = 1'b1;
                end else if (tenure_start) begin
                    state_d = ST_TENURE;
                    load    = held[0] & (|ext_req);
                end else begin
                    state_d = ST_IDLE;
                    load    = 1'b1;
                end
            end
            ST_BLOCK: begin
                state_d = ST_IDLE;
                mask    = 1'b1;
                load    = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign int_gnt = gnt_vec[0];
    assign ext_gnt = gnt_vec[GW-1:1];

    // Checks
    assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_gnt, ext_gnt}));

    assert_tenure_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TENURE && !addr_ack) |=> $stable({int_gnt, ext_gnt}));

    assert_ack_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TENURE && addr_ack && ext_req == '0) |=> (int_gnt || addr_retry));

    assert_retry_holdoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WINDOW && addr_retry) |=> (!int_gnt && ext_gnt == '0));

    assert_idle_top_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !tenure_start && ext_req[0]) |=> ext_gnt[0]);
endmodule

// File: tb/addr_bus_arbiter_tb.sv
module addr_bus_arbiter_tb_top;
    localparam int N_EXT = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tenure_start = 1'b0;
    logic             addr_ack = 1'b0;
    logic             addr_retry = 1'b0;
    logic [N_EXT-1:0] ext_req = '0;
    logic             int_gnt;
    logic [N_EXT-1:0] ext_gnt;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;  // 125 MHz

    addr_bus_arbiter #(.N_EXT(N_EXT)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tenure_start (tenure_start),
        .addr_ack     (addr_ack),
        .addr_retry   (addr_retry),
        .ext_req      (ext_req),
        .int_gnt      (int_gnt),
        .ext_gnt      (ext_gnt)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic exp_int, input logic [N_EXT-1:0] exp_ext);
        n_checks++;
        if (int_gnt !== exp_int || ext_gnt !== exp_ext) begin
            n_fail++;
            $display("FAIL %s: int_gnt=%b ext_gnt=%b, expected int_gnt=%b ext_gnt=%b",
                     req, int_gnt, ext_gnt, exp_int, exp_ext);
        end
        n_checks++;
        if ($countones({int_gnt, ext_gnt}) > 1) begin
            n_fail++;
            $display("FAIL R9: grants %b%b, expected at most one set", int_gnt, ext_gnt);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step();
        chk("R1 reset", 1'b1, 2'b00);
        rst_n = 1'b1;
        step();
        chk("R1 after release", 1'b1, 2'b00);
    endtask

    task automatic t_idle();
        ext_req = 2'b10;
        step();
        chk("R3 idle request", 1'b0, 2'b10);
        ext_req = 2'b00;
        step();
        chk("R2 idle park", 1'b1, 2'b00);
    endtask

    task automatic t_priority();
        ext_req = 2'b11;
        step();
        chk("R4 lowest index wins", 1'b0, 2'b01);
        ext_req = 2'b00;
        step();
        chk("R2 park again", 1'b1, 2'b00);
    endtask

    task automatic t_tenure();
        tenure_start = 1'b1; ext_req = 2'b01;
        step();
        chk("R5 handover at tenure start", 1'b0, 2'b01);
        tenure_start = 1'b0; ext_req = 2'b10;
        step();
        step();
        chk("R6 frozen during tenure", 1'b0, 2'b01);
        addr_ack = 1'b1;
        step();
        chk("R7 winner at ack", 1'b0, 2'b10);
        addr_ack = 1'b0;
        step();
        chk("R7 holder kept in idle", 1'b0, 2'b10);
        tenure_start = 1'b1;
        step();
        tenure_start = 1'b0; ext_req = 2'b00;
        step();
        chk("R6 cancel not seen in tenure", 1'b0, 2'b10);
        addr_ack = 1'b1;
        step();
        chk("R7 cancelled request parks", 1'b1, 2'b00);
        addr_ack = 1'b0;
        step();
    endtask

    task automatic t_retry();
        tenure_start = 1'b1;
        step();
        chk("R5 no request keeps park", 1'b1, 2'b00);
        tenure_start = 1'b0; ext_req = 2'b01; addr_ack = 1'b1;
        step();
        chk("R7 grant after ack", 1'b0, 2'b01);
        addr_ack = 1'b0; addr_retry = 1'b1;
        #1;
        chk("R8 masked in retry cycle", 1'b0, 2'b00);
        step();
        addr_retry = 1'b0;
        chk("R8 masked cycle after retry", 1'b0, 2'b00);
        step();
        chk("R8 regrant after hold-off", 1'b0, 2'b01);
        tenure_start = 1'b1;
        step();
        tenure_start = 1'b0; addr_ack = 1'b1;
        step();
        addr_ack = 1'b0; tenure_start = 1'b1;
        step();
        tenure_start = 1'b0; ext_req = 2'b10;
        step();
        chk("R8 window accepts tenure start", 1'b0, 2'b01);
        addr_ack = 1'b1;
        step();
        addr_ack = 1'b0;
        chk("R7 ack after window tenure", 1'b0, 2'b10);
        ext_req = 2'b00;
        step();
        chk("R2 final park", 1'b1, 2'b00);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_priority();
        t_tenure();
        t_retry();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule